// File: doc/BRIEF.md
# Cell Transmit FIFO Port

This block sits on the physical-layer side of a byte-wide cell transmit interface. An upstream cell source pushes fixed-length cells of 53 bytes, one byte per clock, using an enable strobe, a start-of-cell marker, an 8-bit data bus and a parity bit. The port checks every accepted byte for parity and tracks the position of each byte inside its cell. Whole cells are stored in an internal FIFO that holds four cells, and they become visible to a downstream consumer only once the 53rd byte has arrived.

The block tells the sender when it may write through a single available flag. It has two flow-control policies, picked by a mode input that is low out of reset. In whole-cell policy the flag promises room for a complete cell and is kept up through a cell until the end of that cell is near. In per-byte policy the flag is raised whenever a single byte slot is free and drops as soon as the store is full. The downstream side is a valid/ready read port that marks the first and last byte of every cell. A cell broken by a misplaced start marker is thrown away. Sticky flags record parity and framing faults.

Top module: `utopia_tx_port`

## Requirements
- R1: A cell opened by a byte with `tx_soc` high and completed by 52 further accepted bytes appears on the read port in order. Its first byte has `rd_sop` high and its 53rd byte has `rd_eop` high. No byte of the cell is offered (`rd_valid` stays low for it) until its 53rd byte has been accepted.
- R2: A byte is taken only on a clock with `tx_en` high. Clocks with `tx_en` low inside a cell leave the cell content unchanged, and the transfer resumes with the next enabled byte.
- R3: A new `tx_soc` byte on the clock right after the 53rd byte of a cell starts the next cell, with no gap and no framing error.
- R4: With `byte_mode` low (the reset default), outside a cell `tx_clav` is high exactly when the committed unread bytes plus 53 fit in the 212-byte store. It is high when the store is empty, low when four unread cells are stored, and low when a single free byte exists.
- R5: With `byte_mode` low, `tx_clav` stays high while a cell has fewer than 52 accepted bytes. From 52 accepted bytes on, it shows whether one further whole cell would fit after the current one.
- R6: With `byte_mode` high, `tx_clav` is high exactly when at least one byte slot is free. The store never holds more than 212 bytes, so after four unread cells it is low, and after one byte is read it is high again.
- R7: Parity is odd: a byte is good when its 8 data bits and `tx_par` together hold an odd number of ones (byte 0x00 needs `tx_par` = 1). An accepted bad byte sets `parity_err`, which stays set until reset. The cell is still delivered.
- R8: A `tx_soc` byte accepted while a cell is in progress discards the partial cell, sets the sticky `frame_err`, and becomes byte 1 of a new cell.
- R9: A byte accepted outside a cell without `tx_soc` is discarded, is never delivered, and sets `frame_err`.
- R10: `rd_valid` is high while committed unread bytes exist. While `rd_valid` is high and `rd_ready` is low, `rd_valid`, `rd_data`, `rd_sop` and `rd_eop` hold their values.
- R11: After reset `tx_clav` is high, `rd_valid` is low, and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | 0: whole-cell flow control, 1: per-byte flow control |
| tx_en | input | 1 | Sender strobe; byte taken when high |
| tx_soc | input | 1 | Marks the first byte of a cell |
| tx_data | input | 8 | Cell byte from the sender |
| tx_par | input | 1 | Odd parity bit for `tx_data` |
| tx_clav | output | 1 | Room available for the sender |
| rd_ready | input | 1 | Consumer accepts the offered byte |
| rd_valid | output | 1 | A committed byte is offered |
| rd_data | output | 8 | Offered byte |
| rd_sop | output | 1 | Offered byte is the first of its cell |
| rd_eop | output | 1 | Offered byte is the last of its cell |
| parity_err | output | 1 | Sticky parity fault flag |
| frame_err | output | 1 | Sticky framing fault flag |

## Verification
The bench probes the 52-byte point of a cell when three cells already sit unread. There, a design that drops the flag too early breaks a legal transfer, and one that keeps it up too long lets a fifth cell overrun the store. It fills the store byte by byte in per-byte mode and then frees a single slot. A flag computed with the whole-cell rule would stall for good there, and a missing full check would overwrite unread data. A start marker in the middle of a cell, and stray bytes outside any cell, must leave no trace on the read port: a design that rolls back the write pointer badly would deliver fragments or lose the following good cell. Back-to-back cells and cells with pauses catch counters that slip or reset at the wrong byte.

// File: rtl/utx_pkg.sv
package utx_pkg;

   // write request from the framing tracker to the byte store
   typedef struct packed {
      logic wr;        // store the current byte
      logic rollback;  // restart at the first byte of the open cell
      logic commit;    // this byte closes the cell; publish it
   } utx_wcmd_t;

endpackage

// File: rtl/utx_frame.sv
module utx_frame
   import utx_pkg::*;
#(
   parameter int CELL  = 53,
   parameter int OFF_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc,
   input  logic             soc,
   output utx_wcmd_t        cmd,
   output logic             in_cell,
   output logic [OFF_W-1:0] cnt,
   output logic             frame_hit
);

   localparam logic [OFF_W-1:0] LAST = OFF_W'(CELL - 1);
   localparam logic [OFF_W-1:0] ONE  = OFF_W'(1);

   logic             in_n;
   logic [OFF_W-1:0] cnt_n;

   always_comb begin
      cmd       = '0;
      frame_hit = 1'b0;
      in_n      = in_cell;
      cnt_n     = cnt;
      if (acc) begin
         if (soc) begin
            cmd.wr       = 1'b1;
            cmd.rollback = in_cell;
            frame_hit    = in_cell;
            in_n         = 1'b1;
            cnt_n        = ONE;
         end else if (!in_cell) begin
            frame_hit = 1'b1;
         end else begin
            cmd.wr = 1'b1;
            if (cnt == LAST) begin
               cmd.commit = 1'b1;
               in_n       = 1'b0;
               cnt_n      = '0;
            end else begin
               cnt_n = cnt + ONE;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_cell <= 1'b0;
         cnt     <= '0;
      end else begin
         in_cell <= in_n;
         cnt     <= cnt_n;
      end
   end

endmodule

// File: rtl/utx_store.sv
module utx_store
   import utx_pkg::*;
#(
   parameter int W     = 8,
   parameter int CELL  = 53,
   parameter int DEPTH = 212,
   parameter int IDX_W = 8,
   parameter int CNT_W = 8,
   parameter int OFF_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  utx_wcmd_t        cmd,
   input  logic [W-1:0]     wdata,
   input  logic             rd_ready,
   output logic             rd_valid,
   output logic [W-1:0]     rd_data,
   output logic             rd_sop,
   output logic             rd_eop,
   output logic [CNT_W-1:0] com_cnt,
   output logic [CNT_W-1:0] pend_cnt
);

   localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(DEPTH - 1);
   localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(CELL - 1);
   localparam logic [CNT_W-1:0] CELL_C   = CNT_W'(CELL);
   localparam logic [CNT_W-1:0] ONE_C    = CNT_W'(1);

   function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
      return (i == TOP_IDX) ? '0 : i + IDX_W'(1);
   endfunction

   logic [W-1:0]     mem [DEPTH];
   logic [IDX_W-1:0] rd_idx, base_idx, wr_idx, waddr, wnext;
   logic [OFF_W-1:0] rd_off;
   logic             pop;
   logic [CNT_W-1:0] com_nx;

   assign waddr    = cmd.rollback ? base_idx : wr_idx;
   assign wnext    = step(waddr);
   assign rd_valid = (com_cnt != '0);
   assign pop      = rd_valid & rd_ready;
   assign rd_data  = mem[rd_idx];
   assign rd_sop   = (rd_off == '0);
   assign rd_eop   = (rd_off == LAST_OFF);

   always_comb begin
      com_nx = com_cnt;
      if (pop)        com_nx = com_nx - ONE_C;
      if (cmd.commit) com_nx = com_nx + CELL_C;
   end

   always_ff @(posedge clk) begin
      if (cmd.wr) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_idx   <= '0;
         base_idx <= '0;
         wr_idx   <= '0;
         rd_off   <= '0;
         com_cnt  <= '0;
         pend_cnt <= '0;
      end else begin
         com_cnt <= com_nx;
         if (pop) begin
            rd_idx <= step(rd_idx);
            rd_off <= (rd_off == LAST_OFF) ? '0 : rd_off + OFF_W'(1);
         end
         if (cmd.wr) begin
            wr_idx <= wnext;
            if (cmd.commit) begin
               base_idx <= wnext;
               pend_cnt <= '0;
            end else if (cmd.rollback) begin
               pend_cnt <= ONE_C;
            end else begin
               pend_cnt <= pend_cnt + ONE_C;
            end
         end
      end
   end

endmodule

// File: rtl/utx_flow.sv
module utx_flow #(
   parameter int CELL         = 53,
   parameter int DEPTH        = 212,
   parameter int CNT_W        = 8,
   parameter int OFF_W        = 6,
   parameter bit BYTE_MODE_EN = 1'b1
) (
   input  logic             byte_mode,
   input  logic             in_cell,
   input  logic [OFF_W-1:0] cnt,
   input  logic [CNT_W-1:0] com_cnt,
   input  logic [CNT_W-1:0] pend_cnt,
   output logic             clav,
   output logic             space_ok
);

   localparam logic [CNT_W:0]   DEPTH_X = (CNT_W + 1)'(DEPTH);
   localparam logic [CNT_W:0]   CELL_X  = (CNT_W + 1)'(CELL);
   localparam logic [OFF_W-1:0] LAST    = OFF_W'(CELL - 1);

   logic [CNT_W:0] used, need;
   logic           mid, room, cell_clav;

   assign used      = {1'b0, com_cnt} + {1'b0, pend_cnt};
   assign space_ok  = (used < DEPTH_X);
   assign need      = {1'b0, com_cnt} + (in_cell ? CELL_X : '0) + CELL_X;
   assign room      = (need <= DEPTH_X);
   assign mid       = in_cell && (cnt < LAST);
   assign cell_clav = mid | room;

   generate
      if (BYTE_MODE_EN) begin : g_dual
         assign clav = byte_mode ? space_ok : cell_clav;
      end else begin : g_cell_only
         logic unused_mode;
         assign unused_mode = byte_mode;
         assign clav = cell_clav;
      end
   endgenerate

endmodule

// File: rtl/utopia_tx_port.sv
module utopia_tx_port
   import utx_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int CELL_BYTES   = 53,
   parameter int FIFO_CELLS   = 4,
   parameter bit PAR_ODD      = 1'b1,
   parameter bit BYTE_MODE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_mode,
   input  logic              tx_en,
   input  logic              tx_soc,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_par,
   output logic              tx_clav,
   input  logic              rd_ready,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_sop,
   output logic              rd_eop,
   output logic              parity_err,
   output logic              frame_err
);

   localparam int DEPTH = CELL_BYTES * FIFO_CELLS;
   localparam int IDX_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int OFF_W = $clog2(CELL_BYTES);

   generate
      if (CELL_BYTES < 2) begin : g_bad_cell
         $error("CELL_BYTES must be at least 2");
      end
      if (FIFO_CELLS < 2) begin : g_bad_depth
         $error("FIFO_CELLS must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
   endgenerate

   utx_wcmd_t        wcmd;
   logic             space_ok, acc, in_cell, par_ok, frame_hit;
   logic [OFF_W-1:0] cell_cnt;
   logic [CNT_W-1:0] com_cnt, pend_cnt;

   assign acc = tx_en & space_ok;

   generate
      if (PAR_ODD) begin : g_par_odd
         assign par_ok = ^{tx_data, tx_par};
      end else begin : g_par_even
         assign par_ok = ~^{tx_data, tx_par};
      end
   endgenerate

   utx_frame #(.CELL(CELL_BYTES), .OFF_W(OFF_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (acc),
      .soc       (tx_soc),
      .cmd       (wcmd),
      .in_cell   (in_cell),
      .cnt       (cell_cnt),
      .frame_hit (frame_hit)
   );

   utx_store #(
      .W(DATA_W), .CELL(CELL_BYTES), .DEPTH(DEPTH),
      .IDX_W(IDX_W), .CNT_W(CNT_W), .OFF_W(OFF_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (wcmd),
      .wdata    (tx_data),
      .rd_ready (rd_ready),
      .rd_valid (rd_valid),
      .rd_data  (rd_data),
      .rd_sop   (rd_sop),
      .rd_eop   (rd_eop),
      .com_cnt  (com_cnt),
      .pend_cnt (pend_cnt)
   );

   utx_flow #(
      .CELL(CELL_BYTES), .DEPTH(DEPTH), .CNT_W(CNT_W),
      .OFF_W(OFF_W), .BYTE_MODE_EN(BYTE_MODE_EN)
   ) u_flow (
      .byte_mode (byte_mode),
      .in_cell   (in_cell),
      .cnt       (cell_cnt),
      .com_cnt   (com_cnt),
      .pend_cnt  (pend_cnt),
      .clav      (tx_clav),
      .space_ok  (space_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         parity_err <= 1'b0;
         frame_err  <= 1'b0;
      end else begin
         if (acc && !par_ok) parity_err <= 1'b1;
         if (frame_hit)      frame_err  <= 1'b1;
      end
   end

endmodule

// File: rtl/utx_port_chk.sv
module utx_port_chk #(
   parameter int CELL  = 53,
   parameter int DEPTH = 212,
   parameter int CNT_W = 8,
   parameter int OFF_W = 6,
   parameter int W     = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             byte_mode,
   input logic             tx_clav,
   input logic             rd_ready,
   input logic             rd_valid,
   input logic [W-1:0]     rd_data,
   input logic             rd_sop,
   input logic             rd_eop,
   input logic             parity_err,
   input logic             frame_err,
   input logic             in_cell,
   input logic [OFF_W-1:0] cell_cnt,
   input logic [CNT_W-1:0] com_cnt,
   input logic [CNT_W-1:0] pend_cnt
);

   localparam logic [CNT_W:0]   DEPTH_X = (CNT_W + 1)'(DEPTH);
   localparam logic [OFF_W-1:0] LAST    = OFF_W'(CELL - 1);

   // R6: stored plus in-flight bytes never exceed the store
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, com_cnt} + {1'b0, pend_cnt}) <= DEPTH_X);

   // R7: parity fault flag is sticky
   p_par_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      parity_err |=> parity_err);

   // R8: framing fault flag is sticky
   p_frm_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> frame_err);

   // R10: offered byte holds while the consumer stalls
   p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=>
         (rd_valid && $stable(rd_data) && $stable(rd_sop) && $stable(rd_eop)));

   // R1: a cell cannot start and end on the same byte
   p_sop_eop_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !(rd_sop && rd_eop));

   // R5: in whole-cell policy the flag only falls outside the early part of a cell
   p_clav_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_mode && $past(!byte_mode) && $fell(tx_clav)) |->
         (!in_cell || cell_cnt >= LAST));

endmodule

bind utopia_tx_port utx_port_chk #(
   .CELL(CELL_BYTES), .DEPTH(DEPTH), .CNT_W(CNT_W), .OFF_W(OFF_W), .W(DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .byte_mode  (byte_mode),
   .tx_clav    (tx_clav),
   .rd_ready   (rd_ready),
   .rd_valid   (rd_valid),
   .rd_data    (rd_data),
   .rd_sop     (rd_sop),
   .rd_eop     (rd_eop),
   .parity_err (parity_err),
   .frame_err  (frame_err),
   .in_cell    (in_cell),
   .cell_cnt   (cell_cnt),
   .com_cnt    (com_cnt),
   .pend_cnt   (pend_cnt)
);

// File: tb/utopia_tx_port_tb.sv
module utopia_tx_port_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int CELL       = 53;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       byte_mode = 1'b0;
   logic       tx_en = 1'b0;
   logic       tx_soc = 1'b0;
   logic [7:0] tx_data = '0;
   logic       tx_par = 1'b1;
   logic       tx_clav;
   logic       rd_ready = 1'b0;
   logic       rd_valid;
   logic [7:0] rd_data;
   logic       rd_sop, rd_eop, parity_err, frame_err;

   int total = 0;
   int bad   = 0;
   int rd_mode = 0;   // 0 stall, 1 always ready, 2 toggle
   logic [9:0] expq[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   utopia_tx_port dut_i (
      .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode),
      .tx_en(tx_en), .tx_soc(tx_soc), .tx_data(tx_data), .tx_par(tx_par),
      .tx_clav(tx_clav), .rd_ready(rd_ready), .rd_valid(rd_valid),
      .rd_data(rd_data), .rd_sop(rd_sop), .rd_eop(rd_eop),
      .parity_err(parity_err), .frame_err(frame_err)
   );

   function automatic logic [7:0] bval(input int s, input int i);
      return 8'((s * 37) + (i * 11));
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // consumer ready pattern, updated away from the edge
   always @(posedge clk) begin
      #2;
      case (rd_mode)
         0:       rd_ready = 1'b0;
         1:       rd_ready = 1'b1;
         default: rd_ready = ~rd_ready;
      endcase
   end

   // monitor: each transferred byte is compared with the scoreboard head (R1)
   always @(negedge clk) begin
      if (rst_n && rd_valid && rd_ready) begin
         total++;
         if (expq.size() == 0) begin
            bad++;
            $display("FAIL R1 unexpected byte: actual=%0h expected=none",
                     {rd_sop, rd_eop, rd_data});
         end else begin
            logic [9:0] e;
            e = expq.pop_front();
            if ({rd_sop, rd_eop, rd_data} !== e) begin
               bad++;
               $display("FAIL R1 read byte: actual=%0h expected=%0h",
                        {rd_sop, rd_eop, rd_data}, e);
            end
         end
      end
   end

   task automatic push_cell(input int s);
      for (int i = 0; i < CELL; i++)
         expq.push_back({(i == 0), (i == CELL - 1), bval(s, i)});
   endtask

   // drives bytes [from,to) of cell s; entered and left at posedge+1
   task automatic send_part(input int s, input int from, input int to,
                            input bit soc0, input int bad_idx,
                            input int pause_at, input int pause_len,
                            input bit hold);
      for (int i = from; i < to; i++) begin
         if (i == pause_at) begin
            tx_en = 1'b0; tx_soc = 1'b0;
            repeat (pause_len) begin @(posedge clk); #1; end
         end
         while ((byte_mode || i == 0) && !tx_clav) begin
            tx_en = 1'b0; tx_soc = 1'b0;
            @(posedge clk); #1;
         end
         tx_en   = 1'b1;
         tx_soc  = soc0 && (i == 0);
         tx_data = bval(s, i);
         tx_par  = (~^bval(s, i)) ^ (i == bad_idx);
         @(posedge clk); #1;
      end
      if (!hold) begin tx_en = 1'b0; tx_soc = 1'b0; end
   endtask

   task automatic send_cell(input int s);
      push_cell(s);
      send_part(s, 0, CELL, 1'b1, -1, -1, 0, 1'b0);
   endtask

   task automatic wait_drain(input string req);
      int n;
      n = 0;
      while ((expq.size() != 0 || rd_valid) && n < 3000) begin
         @(posedge clk); #1; n++;
      end
      check(req, "scoreboard empty", expq.size(), 0);
   endtask

   task automatic do_reset();
      tx_en = 1'b0; tx_soc = 1'b0; rst_n = 1'b0;
      expq.delete();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] held;
      rd_mode = 1;
      do_reset();
      // R11
      check("R11", "clav after reset", tx_clav, 1);
      check("R11", "rd_valid after reset", rd_valid, 0);
      check("R11", "parity_err after reset", parity_err, 0);
      check("R11", "frame_err after reset", frame_err, 0);
      check("R4", "clav empty", tx_clav, 1);

      // R1: nothing offered before byte 53; seed 0 starts with byte 0x00 (R7)
      push_cell(0);
      send_part(0, 0, CELL - 1, 1'b1, -1, -1, 0, 1'b0);
      repeat (3) begin @(posedge clk); #1; end
      check("R1", "no byte before cell end", rd_valid, 0);
      send_part(0, CELL - 1, CELL, 1'b1, -1, -1, 0, 1'b0);
      wait_drain("R1");
      check("R7", "zero byte with parity 1 accepted", parity_err, 0);

      // R2: pauses inside a cell
      push_cell(3);
      send_part(3, 0, CELL, 1'b1, -1, 10, 5, 1'b0);
      push_cell(4);
      send_part(4, 0, CELL, 1'b1, -1, 40, 2, 1'b0);
      wait_drain("R2");

      // R3: back-to-back cells
      push_cell(5);
      send_part(5, 0, CELL, 1'b1, -1, -1, 0, 1'b1);
      push_cell(6);
      send_part(6, 0, CELL, 1'b1, -1, -1, 0, 1'b0);
      wait_drain("R3");
      check("R3", "no framing fault back to back", frame_err, 0);

      // R4/R5: whole-cell policy with the store filling up
      rd_mode = 0;
      @(posedge clk); #1;
      send_cell(10); send_cell(11); send_cell(12);
      check("R4", "clav with three cells stored", tx_clav, 1);
      push_cell(13);
      send_part(13, 0, 20, 1'b1, -1, -1, 0, 1'b0);
      check("R5", "clav held mid cell", tx_clav, 1);
      send_part(13, 20, CELL - 1, 1'b1, -1, -1, 0, 1'b0);
      check("R5", "clav after 52 bytes, no room", tx_clav, 0);
      send_part(13, CELL - 1, CELL, 1'b1, -1, -1, 0, 1'b0);
      check("R4", "clav with four cells stored", tx_clav, 0);
      // R10: stalled read holds
      check("R10", "rd_valid while stored", rd_valid, 1);
      held = rd_data;
      repeat (3) begin @(posedge clk); #1; end
      check("R10", "rd_data held during stall", rd_data, held);
      check("R10", "head byte value", rd_data, bval(10, 0));
      rd_mode = 1;
      wait_drain("R4");
      check("R4", "clav after drain", tx_clav, 1);

      // R6: per-byte policy
      byte_mode = 1'b1;
      rd_mode = 0;
      @(posedge clk); #1;
      send_cell(20); send_cell(21); send_cell(22); send_cell(23);
      check("R6", "clav with store full", tx_clav, 0);
      rd_mode = 1;
      @(posedge clk); #1;
      rd_mode = 0;
      @(posedge clk); #1;
      @(posedge clk); #1;
      check("R6", "clav with one free byte", tx_clav, 1);
      byte_mode = 1'b0;
      #1;
      check("R4", "whole-cell clav with one free byte", tx_clav, 0);
      byte_mode = 1'b1;
      #1;
      rd_mode = 2;
      send_cell(24);
      rd_mode = 1;
      wait_drain("R6");
      byte_mode = 1'b0;
      @(posedge clk); #1;

      // R7: bad parity flagged, cell still delivered
      push_cell(30);
      send_part(30, 0, CELL, 1'b1, 5, -1, 0, 1'b0);
      check("R7", "parity fault flagged", parity_err, 1);
      wait_drain("R7");
      check("R7", "parity fault sticky", parity_err, 1);

      // R8: start marker mid cell
      check("R8", "no framing fault yet", frame_err, 0);
      send_part(40, 0, 30, 1'b1, -1, -1, 0, 1'b1);
      send_cell(41);
      check("R8", "framing fault flagged", frame_err, 1);
      wait_drain("R8");

      // R9: stray bytes outside a cell
      do_reset();
      send_part(50, 5, 15, 1'b0, -1, -1, 0, 1'b0);
      repeat (2) begin @(posedge clk); #1; end
      check("R9", "stray bytes not offered", rd_valid, 0);
      check("R9", "framing fault flagged", frame_err, 1);
      send_cell(51);
      wait_drain("R9");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule